// File: doc/BRIEF.md
# Flash access security filter

This block sits between a CPU-side flash access port and a data flash controller and enforces read and write protection on a set of sectors. After reset it waits a start-up interval, then reads two 16-bit protection vectors from a reserved security sector. It decodes the protection settings from the first vector together with the boot-mode pins, and latches them when the second read completes. Only then does it open the CPU port.

Once open, reads of read-protected sectors return zero, and no flag shows that the data was masked. Writes to write-protected sectors are dropped. A full chip erase is always let through. A dropped write puts the flash into reset, closes the port for a recovery interval and then reads the vectors again. In command-sequencer mode it also sets a sticky write-error flag. An external disable input removes all protection, but the start-up interval and the vector reads still take place.

The flash is modelled with a combinational read path: `fl_rdata` is valid in the same cycle as `fl_req`.

Top module: `flash_guard`

## Requirements
- R1: After reset is released, `cpu_ready` stays low for exactly BOOT_CYC+2 cycles. During that time the block reads the flash once at byte address SEC_BASE and once at SEC_BASE+2. This also holds when `prot_dis` is 1.
- R2: While `cpu_ready` is low, no CPU read, write or erase reaches the flash, even if `cpu_req` is held high.
- R3: A read of a sector under active read protection returns 0x0000 on `cpu_rdata`, and no output signals that the read was masked.
- R4: A write (`cpu_we`=1, `cpu_erase`=0) to a sector under active write protection is not forwarded: `fl_we` stays low.
- R5: A cancelled write raises `fl_rst` and drops `cpu_ready` for exactly RECOV_CYC+2 cycles. During that window the two vectors are read again.
- R6: With `cpu_seq_mode`=1, a cancelled write sets `wr_err`. `wr_err` clears when a write or erase is next forwarded to the flash.
- R7: With `cpu_seq_mode`=0 (direct mode), a cancelled write leaves `wr_err` unchanged.
- R8: A chip erase (`cpu_erase`=1) is always forwarded as `fl_erase`, whatever the protection settings.
- R9: In vector 1, bit 0 enables read protection, bit 1 enables write protection and bit 2 is the level bit. A sector is protected when bit `cpu_addr[AW-1:SEC_SH]` of PROT_MASK is 1. Unprotected sectors are never masked or blocked.
- R10: With `boot_md`=3'b000 (internal-vector boot), read protection never applies. Write protection is lifted in that mode when the level bit is 1, and kept when it is 0. In every other mode both protections follow their enable bits.
- R11: If any of bits 15:3 of vector 1 is 1, the vector is treated as invalid and both read and write protection apply in every boot mode.
- R12: When `prot_dis` is 1, reads return flash data and writes are forwarded in every sector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prot_dis | input | 1 | 1 removes all protection |
| boot_md | input | 3 | Boot-mode pins; 000 is internal-vector boot |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 write, 0 read |
| cpu_erase | input | 1 | Chip erase request; takes priority over cpu_we |
| cpu_seq_mode | input | 1 | 1 command-sequencer mode, 0 direct mode |
| cpu_addr | input | AW | Byte address |
| cpu_wdata | input | 16 | Write data |
| cpu_ready | output | 1 | Port open; a request is taken in a cycle with cpu_ready high |
| cpu_rdata | output | 16 | Read data, zero when masked |
| wr_err | output | 1 | Sticky write-error flag |
| fl_req | output | 1 | Flash access strobe |
| fl_we | output | 1 | Flash write strobe |
| fl_erase | output | 1 | Flash chip-erase strobe |
| fl_addr | output | AW | Flash byte address |
| fl_wdata | output | 16 | Flash write data |
| fl_rdata | input | 16 | Flash read data, same cycle as fl_req |
| fl_rst | output | 1 | Flash reset during recovery |

## Verification
A wrong latched protection state appears in the very cycle of the next access to a protected sector. It shows as a nonzero `cpu_rdata` where zero is due, as zero data where real data is due, or as a wrong `fl_we` strobe. A sequencer in the wrong state shows as a ready window one or more cycles off the computed BOOT_CYC+2 or RECOV_CYC+2, or as missing vector reads. A dropped error update shows as `wr_err` holding its old value in the cycle after the cancelled write.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int VEC_W = 16;

  typedef enum logic [2:0] {
    SQ_BOOT,
    SQ_VEC1,
    SQ_VEC2,
    SQ_RUN,
    SQ_RECOV
  } seq_state_e;

  typedef struct packed {
    logic rd;
    logic wr;
  } prot_t;

  // Decode protection from vector 1 and the boot-mode pins.
  function automatic prot_t prot_decode(input logic [VEC_W-1:0] v1, input logic [2:0] md);
    prot_t p;
    logic  int_boot;
    int_boot = (md == 3'b000);
    if (|v1[VEC_W-1:3]) begin
      p.rd = 1'b1;
      p.wr = 1'b1;
    end else begin
      p.rd = v1[0] & ~int_boot;
      p.wr = v1[1] & ~(v1[2] & int_boot);
    end
    return p;
  endfunction
endpackage

// File: rtl/fg_seq.sv
module fg_seq
  import flash_guard_pkg::*;
#(
  parameter int unsigned BOOT_CYC  = 150000,
  parameter int unsigned RECOV_CYC = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic viol,
  output logic ready,
  output logic in_fetch,
  output logic fetch_sel,
  output logic cap_v1,
  output logic commit,
  output logic flash_rst
);
  localparam int unsigned MAXC = (BOOT_CYC > RECOV_CYC) ? BOOT_CYC : RECOV_CYC;
  localparam int CW = $clog2(MAXC + 1);

  seq_state_e      st;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= SQ_BOOT;
      cnt <= '0;
    end else begin
      case (st)
        SQ_BOOT: begin
          if (cnt == CW'(BOOT_CYC - 1)) begin
            st  <= SQ_VEC1;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_VEC1: st <= SQ_VEC2;
        SQ_VEC2: st <= SQ_RUN;
        SQ_RUN: begin
          cnt <= '0;
          if (viol) st <= SQ_RECOV;
        end
        SQ_RECOV: begin
          if (cnt == CW'(RECOV_CYC - 1)) begin
            st  <= SQ_VEC1;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= SQ_BOOT;
      endcase
    end
  end

  assign ready     = (st == SQ_RUN);
  assign in_fetch  = (st == SQ_VEC1) || (st == SQ_VEC2);
  assign fetch_sel = (st == SQ_VEC2);
  assign cap_v1    = (st == SQ_VEC1);
  assign commit    = (st == SQ_VEC2);
  assign flash_rst = (st == SQ_RECOV);
endmodule

// File: rtl/fg_policy.sv
module fg_policy
  import flash_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_v1,
  input  logic             commit,
  input  logic [VEC_W-1:0] vec_in,
  input  logic [2:0]       md,
  output prot_t            prot
);
  logic [VEC_W-1:0] v1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= '1;
      prot <= '{rd: 1'b1, wr: 1'b1};
    end else begin
      if (cap_v1) v1_q <= vec_in;
      if (commit) prot <= prot_decode(v1_q, md);
    end
  end
endmodule

// File: rtl/fg_gate.sv
module fg_gate
  import flash_guard_pkg::*;
#(
  parameter int AW     = 16,
  parameter int SEC_SH = 12,
  parameter logic [(1<<(AW-SEC_SH))-1:0] PROT_MASK = 'h00F0,
  parameter logic [AW-1:0] SEC_BASE = 'hFF00
) (
  input  logic             cpu_req,
  input  logic             cpu_we,
  input  logic             cpu_erase,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [VEC_W-1:0] cpu_wdata,
  input  logic             ready,
  input  logic             in_fetch,
  input  logic             fetch_sel,
  input  prot_t            prot,
  input  logic             dis,
  input  logic [VEC_W-1:0] fl_rdata,
  output logic             fl_req,
  output logic             fl_we,
  output logic             fl_erase,
  output logic [AW-1:0]    fl_addr,
  output logic [VEC_W-1:0] fl_wdata,
  output logic [VEC_W-1:0] cpu_rdata,
  output logic             viol,
  output logic             rd_block,
  output logic             accept
);
  logic sec_hit, wr_block, is_wr, is_rd;

  assign sec_hit  = PROT_MASK[cpu_addr[AW-1:SEC_SH]];
  assign rd_block = sec_hit & prot.rd & ~dis;
  assign wr_block = sec_hit & prot.wr & ~dis;
  assign accept   = cpu_req & ready;
  assign is_wr    = cpu_we & ~cpu_erase;
  assign is_rd    = ~cpu_we & ~cpu_erase;
  assign viol     = accept & is_wr & wr_block;

  always_comb begin
    if (in_fetch) begin
      fl_req   = 1'b1;
      fl_we    = 1'b0;
      fl_erase = 1'b0;
      fl_addr  = SEC_BASE + (fetch_sel ? AW'(2) : AW'(0));
    end else begin
      fl_req   = accept & ~viol;
      fl_we    = accept & is_wr & ~viol;
      fl_erase = accept & cpu_erase;
      fl_addr  = cpu_addr;
    end
  end

  assign fl_wdata  = cpu_wdata;
  assign cpu_rdata = (accept & is_rd & ~rd_block) ? fl_rdata : '0;
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
#(
  parameter int AW     = 16,
  parameter int SEC_SH = 12,
  parameter logic [(1<<(AW-SEC_SH))-1:0] PROT_MASK = 'h00F0,
  parameter logic [AW-1:0] SEC_BASE = 'hFF00,
  parameter int unsigned BOOT_CYC  = 150000,
  parameter int unsigned RECOV_CYC = 30000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_dis,
  input  logic [2:0]    boot_md,
  input  logic          cpu_req,
  input  logic          cpu_we,
  input  logic          cpu_erase,
  input  logic          cpu_seq_mode,
  input  logic [AW-1:0] cpu_addr,
  input  logic [15:0]   cpu_wdata,
  output logic          cpu_ready,
  output logic [15:0]   cpu_rdata,
  output logic          wr_err,
  output logic          fl_req,
  output logic          fl_we,
  output logic          fl_erase,
  output logic [AW-1:0] fl_addr,
  output logic [15:0]   fl_wdata,
  input  logic [15:0]   fl_rdata,
  output logic          fl_rst
);
  logic  viol, rd_block, accept;
  logic  in_fetch, fetch_sel, cap_v1, commit;
  prot_t prot;

  fg_seq #(.BOOT_CYC(BOOT_CYC), .RECOV_CYC(RECOV_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .viol(viol), .ready(cpu_ready),
    .in_fetch(in_fetch), .fetch_sel(fetch_sel), .cap_v1(cap_v1),
    .commit(commit), .flash_rst(fl_rst)
  );

  fg_policy u_policy (
    .clk(clk), .rst_n(rst_n), .cap_v1(cap_v1), .commit(commit),
    .vec_in(fl_rdata), .md(boot_md), .prot(prot)
  );

  fg_gate #(.AW(AW), .SEC_SH(SEC_SH), .PROT_MASK(PROT_MASK), .SEC_BASE(SEC_BASE)) u_gate (
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_erase(cpu_erase),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .ready(cpu_ready),
    .in_fetch(in_fetch), .fetch_sel(fetch_sel), .prot(prot), .dis(prot_dis),
    .fl_rdata(fl_rdata), .fl_req(fl_req), .fl_we(fl_we), .fl_erase(fl_erase),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .cpu_rdata(cpu_rdata),
    .viol(viol), .rd_block(rd_block), .accept(accept)
  );

  // Sticky error flag: set by a cancelled write in sequencer mode,
  // cleared by the next forwarded write or erase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     wr_err <= 1'b0;
    else if (viol && cpu_seq_mode)  wr_err <= 1'b1;
    else if (fl_we || fl_erase)     wr_err <= 1'b0;
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SEC_BASE = 'hFF00
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_ready,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_erase,
  input logic          cpu_seq_mode,
  input logic [15:0]   cpu_rdata,
  input logic          rd_block,
  input logic          accept,
  input logic          viol,
  input logic          wr_err,
  input logic          fl_req,
  input logic          fl_we,
  input logic          fl_erase,
  input logic          fl_rst,
  input logic [AW-1:0] fl_addr,
  input logic          in_fetch
);
  assert_fetch_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_fetch |-> (fl_req && !fl_we && !fl_erase &&
                  (fl_addr == SEC_BASE || fl_addr == SEC_BASE + AW'(2))));

  assert_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_ready |-> !(fl_we || fl_erase));

  assert_read_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !cpu_we && !cpu_erase && rd_block) |-> (cpu_rdata == 16'h0000));

  assert_cancel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    viol |-> !fl_we);

  assert_recover_R5: assert property (@(posedge clk) disable iff (!rst_n)
    viol |=> (fl_rst && !cpu_ready));

  assert_rst_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rst |-> (!cpu_ready && !fl_req));

  assert_werr_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && cpu_seq_mode) |=> wr_err);

  assert_werr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !cpu_seq_mode) |=> (wr_err == $past(wr_err)));

  assert_erase_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && cpu_ready && cpu_erase) |-> fl_erase);
endmodule

bind flash_guard fg_checker #(.AW(AW), .SEC_BASE(SEC_BASE)) u_fg_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ready(cpu_ready), .cpu_req(cpu_req),
  .cpu_we(cpu_we), .cpu_erase(cpu_erase), .cpu_seq_mode(cpu_seq_mode),
  .cpu_rdata(cpu_rdata), .rd_block(rd_block), .accept(accept), .viol(viol),
  .wr_err(wr_err), .fl_req(fl_req), .fl_we(fl_we), .fl_erase(fl_erase),
  .fl_rst(fl_rst), .fl_addr(fl_addr), .in_fetch(in_fetch)
);

// File: tb/test_flash_guard.sv
module test_flash_guard;
  localparam int BOOT  = 20;
  localparam int RECOV = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        prot_dis = 1'b0;
  logic [2:0]  boot_md = 3'b001;
  logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_erase = 1'b0, cpu_seq_mode = 1'b1;
  logic [15:0] cpu_addr = '0, cpu_wdata = 16'h1357;
  logic        cpu_ready, wr_err, fl_req, fl_we, fl_erase, fl_rst;
  logic [15:0] cpu_rdata, fl_addr, fl_wdata, fl_rdata;
  logic [15:0] vec1_cfg = 16'h0000;

  int nchk = 0, nerr = 0;
  int fl_wr_cnt = 0, fl_er_cnt = 0, f1_cnt = 0, f2_cnt = 0;
  bit rst_seen = 0, done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  flash_guard #(.BOOT_CYC(BOOT), .RECOV_CYC(RECOV)) i_flash_guard (
    .clk(clk), .rst_n(rst_n), .prot_dis(prot_dis), .boot_md(boot_md),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_erase(cpu_erase),
    .cpu_seq_mode(cpu_seq_mode), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .wr_err(wr_err),
    .fl_req(fl_req), .fl_we(fl_we), .fl_erase(fl_erase), .fl_addr(fl_addr),
    .fl_wdata(fl_wdata), .fl_rdata(fl_rdata), .fl_rst(fl_rst)
  );

  // Flash model: vector 1 at 0xFF00, vector 2 at 0xFF02, pattern elsewhere.
  assign fl_rdata = (fl_addr == 16'hFF00) ? vec1_cfg :
                    (fl_addr == 16'hFF02) ? 16'h5A5A : (fl_addr ^ 16'hA5C3);

  always @(posedge clk) begin
    if (fl_we) fl_wr_cnt++;
    if (fl_erase) fl_er_cnt++;
    if (fl_rst) rst_seen = 1;
    if (fl_req && !cpu_ready && fl_addr == 16'hFF00) f1_cnt++;
    if (fl_req && !cpu_ready && fl_addr == 16'hFF02) f2_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference model of the protection rules.
  function automatic bit in_prot_sector(input logic [15:0] a);
    return (a[15:12] >= 4'd4) && (a[15:12] <= 4'd7);
  endfunction
  function automatic bit rd_prot(input logic [15:0] v, input logic [2:0] m, input bit d);
    if (d) return 0;
    if (v > 16'd7) return 1;
    return v[0] && (m != 3'b000);
  endfunction
  function automatic bit wr_prot(input logic [15:0] v, input logic [2:0] m, input bit d);
    if (d) return 0;
    if (v > 16'd7) return 1;
    if (m == 3'b000 && v[2]) return 0;
    return v[1];
  endfunction

  // Scoreboard monitor for reads.
  always @(negedge clk) begin
    if (rst_n && cpu_req && cpu_ready && !cpu_we && !cpu_erase) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected read", int'(cpu_rdata), 0);
      else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(cpu_rdata == e, t, int'(cpu_rdata), int'(e));
      end
    end
  end

  task automatic do_reset(input logic [15:0] v, input logic [2:0] m, input bit d);
    int low;
    vec1_cfg = v; boot_md = m; prot_dis = d;
    rst_n = 1'b0;
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_erase = 1'b0; cpu_addr = 16'h1000;
    repeat (3) @(posedge clk);
    #1;
    f1_cnt = 0; f2_cnt = 0;
    begin
      int w0;
      w0 = fl_wr_cnt;
      rst_n = 1'b1;
      low = 0;
      forever begin
        @(negedge clk);
        if (cpu_ready) break;
        low++;
      end
      cpu_req = 1'b0; cpu_we = 1'b0;
      chk(low == BOOT + 2, "R1 startup window", low, BOOT + 2);
      chk(f1_cnt == 1 && f2_cnt == 1, "R1 vector reads", f1_cnt * 16 + f2_cnt, 16'h11);
      chk(fl_wr_cnt == w0, "R2 stalled write", fl_wr_cnt - w0, 0);
    end
  endtask

  task automatic do_read(input logic [15:0] a, input string tag);
    logic [15:0] e;
    e = (in_prot_sector(a) && rd_prot(vec1_cfg, boot_md, prot_dis)) ? 16'h0000 : (a ^ 16'hA5C3);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_erase = 1'b0; cpu_addr = a;
    @(posedge clk); #1;
    cpu_req = 1'b0;
  endtask

  task automatic do_write(input logic [15:0] a, input bit er, input bit sm, input string tag);
    int w0, e0, low;
    bit werr0, blk;
    blk = !er && in_prot_sector(a) && wr_prot(vec1_cfg, boot_md, prot_dis);
    w0 = fl_wr_cnt; e0 = fl_er_cnt; werr0 = wr_err; rst_seen = 0; f1_cnt = 0;
    @(posedge clk); #1;
    cpu_req = 1'b1; cpu_we = !er; cpu_erase = er; cpu_seq_mode = sm; cpu_addr = a;
    @(posedge clk); #1;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_erase = 1'b0;
    if (er) chk(fl_er_cnt == e0 + 1, {tag, " erase forwarded"}, fl_er_cnt - e0, 1);
    else chk(fl_wr_cnt == w0 + (blk ? 0 : 1), {tag, " write forwarded count"}, fl_wr_cnt - w0, blk ? 0 : 1);
    if (blk) begin
      low = 0;
      forever begin
        @(negedge clk);
        if (cpu_ready) break;
        low++;
      end
      chk(low == RECOV + 2, {tag, " R5 recovery window"}, low, RECOV + 2);
      chk(rst_seen && f1_cnt == 1, {tag, " R5 reset and refetch"}, rst_seen * 16 + f1_cnt, 16'h11);
      chk(wr_err == (sm ? 1'b1 : werr0), {tag, sm ? " R6 error set" : " R7 error unchanged"},
          int'(wr_err), int'(sm ? 1'b1 : werr0));
    end else begin
      @(negedge clk);
      chk(wr_err == 1'b0, {tag, " R6 error clear after forward"}, int'(wr_err), 0);
      chk(cpu_ready == 1'b1, {tag, " port stays open"}, int'(cpu_ready), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    #1;
    chk(cpu_ready == 0 && fl_rst == 0 && wr_err == 0, "R1 reset state",
        {cpu_ready, fl_rst, wr_err}, 0);
    // Read protection only, normal boot mode
    do_reset(16'h0001, 3'b001, 1'b0);
    do_read(16'h4010, "R3 masked read");
    do_read(16'h1234, "R9 unprotected sector read");
    do_write(16'h4000, 1'b0, 1'b1, "R9 write with read-only protection");
    // Internal-vector boot lifts read protection
    do_reset(16'h0001, 3'b000, 1'b0);
    do_read(16'h4010, "R10 boot mode read");
    // Write protection, level 0
    do_reset(16'h0002, 3'b001, 1'b0);
    do_read(16'h5010, "R9 write-only vector read");
    do_write(16'h5000, 1'b0, 1'b1, "R4 cancel seq");
    do_write(16'h1000, 1'b0, 1'b1, "R6 clear");
    do_write(16'h6000, 1'b0, 1'b0, "R7 cancel direct");
    do_write(16'h6000, 1'b1, 1'b1, "R8 chip erase");
    // Level bit with boot mode
    do_reset(16'h0006, 3'b000, 1'b0);
    do_write(16'h4000, 1'b0, 1'b1, "R10 level1 boot mode");
    do_reset(16'h0006, 3'b010, 1'b0);
    do_write(16'h4000, 1'b0, 1'b1, "R10 level1 other mode");
    do_reset(16'h0002, 3'b000, 1'b0);
    do_write(16'h4000, 1'b0, 1'b1, "R10 level0 boot mode");
    // Invalid vector fails safe
    do_reset(16'h0008, 3'b000, 1'b0);
    do_read(16'h4004, "R11 invalid vector read");
    do_write(16'h7000, 1'b0, 1'b1, "R11 invalid vector write");
    // Disable pin
    do_reset(16'h0003, 3'b001, 1'b1);
    do_read(16'h4020, "R12 disabled read");
    do_write(16'h4000, 1'b0, 1'b1, "R12 disabled write");
    repeat (3) @(posedge clk);
    chk(exp_q.size() == 0, "R3 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule